// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Sense Controller

This block watches the effective input value of a GPIO port and raises per-pin interrupt flags. For each pin, the effective input is taken from the output latch when the pin is driven as an output. It is taken from the synchronized external pad level when the pin is an input. Because of this, an output pin can trigger on the transitions it drives itself. Each pin carries a 3-bit sense code that selects one of five modes: off, any change, rising edge, falling edge or low level. There is no port-wide enable, so a pin is armed only through its own code.

Detected events are ORed into a sticky flag register. Software clears a flag by presenting a write-one-to-clear mask, which the surrounding register block decodes into a one-cycle strobe. A single interrupt request line is the OR of all flags. It stays high until every flag has been cleared.

The external pad levels pass through a parameterised synchronizer chain. Edge detection compares the current effective input with the value registered one clock earlier. After reset, detection stays disarmed until both the synchronizer and the history register hold real pin data.

Top module: `gpio_pin_sense`

## Requirements
- R1: The effective input of pin i is `out[i]` when `dir[i]` is 1 and the synchronized `pad[i]` when `dir[i]` is 0. While `dir[i]` is 1, changes on `pad[i]` never set a flag, and changes on `out[i]` do.
- R2: The sense code of pin i is `sense_cfg[3*i+2:3*i]`, encoded 0 off, 1 any change, 2 rising, 3 falling, 5 low level. Codes 4, 6 and 7 behave as off.
- R3: In any-change mode, a flag is set both when the effective input goes 0 to 1 and when it goes 1 to 0.
- R4: In rising mode, a flag is set only when the effective input goes from 0 to 1, never on a 1 to 0 change.
- R5: In falling mode, a flag is set only when the effective input goes from 1 to 0, never on a 0 to 1 change.
- R6: In low-level mode, the flag is set on every clock in which the effective input is 0, so a clear issued while the level is still low leaves the flag set.
- R7: A pin whose code is off never sets its flag, whatever its input does.
- R8: A set flag stays set until a clock in which `clr_mask[i]` is 1, after which it reads 0. A 0 bit in the mask leaves its flag unchanged.
- R9: When a new event and a clear hit the same flag in the same clock, the flag ends up set.
- R10: `irq` is high exactly when at least one flag is set, and it updates on the same clock edge as the flags.
- R11: A change on `pad` reaches the flags SYNC_STAGES+1 rising edges after it is sampled. A change on `dir` or `out` reaches them on the next rising edge.
- R12: Reset clears the flags and `irq`. For the first SYNC_STAGES+1 rising edges after reset is released, no event is detected, so no flag can be set in that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir | input | N_PINS | Direction per pin, 1 = output |
| out | input | N_PINS | Output latch value per pin |
| pad | input | N_PINS | Raw external pin levels, asynchronous |
| sense_cfg | input | 3*N_PINS | Sense code per pin, 3 bits each, pin 0 lowest |
| clr_mask | input | N_PINS | Write-one-to-clear strobe for the flags |
| flags | output | N_PINS | Sticky interrupt flags |
| irq | output | 1 | Interrupt request, OR of the flags |

## Verification
Changes driven on `dir` or `out` are due in the flags and `irq` one rising edge later. Pad changes are due SYNC_STAGES+1 edges later, which is three with the default settings. The bench steps the clock one edge at a time and samples at the falling edge. It places each directed check on the exact edge count from its stimulus, and also checks the edge just before a pad-driven result to confirm that nothing arrives early. A reference model in the bench applies the same pad delay and the same arming window to the random traffic, and it is compared against the outputs after every edge.

// File: rtl/gps_pkg.sv
package gps_pkg;

   localparam int SENSE_W = 3;

   typedef enum logic [SENSE_W-1:0] {
      SENSE_OFF  = 3'd0,
      SENSE_ANY  = 3'd1,
      SENSE_RISE = 3'd2,
      SENSE_FALL = 3'd3,
      SENSE_LOW  = 3'd5
   } sense_e;

   // Undefined codes fold to off.
   function automatic sense_e to_sense(input logic [SENSE_W-1:0] code);
      case (code)
         3'd1:    return SENSE_ANY;
         3'd2:    return SENSE_RISE;
         3'd3:    return SENSE_FALL;
         3'd5:    return SENSE_LOW;
         default: return SENSE_OFF;
      endcase
   endfunction

   function automatic logic sense_hit(input sense_e mode, input logic prv, input logic cur);
      case (mode)
         SENSE_ANY:  return prv ^ cur;
         SENSE_RISE: return ~prv & cur;
         SENSE_FALL: return prv & ~cur;
         SENSE_LOW:  return ~cur;
         default:    return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/gps_sync.sv
module gps_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin
      assert (STAGES >= 0 && STAGES <= 4) else $error("gps_sync: STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= d;
               for (int s = 1; s < STAGES; s++) begin
                  sh_q[s] <= sh_q[s-1];
               end
            end
         end
         assign q = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/gps_detect.sv
module gps_detect
   import gps_pkg::*;
#(
   parameter int N_PINS      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_PINS-1:0]           dir,
   input  logic [N_PINS-1:0]           out,
   input  logic [N_PINS-1:0]           pad_sync,
   input  logic [N_PINS*SENSE_W-1:0]   sense_cfg,
   output logic [N_PINS-1:0]           evt,
   output logic                        armed
);

   localparam int ARM_LAST = SYNC_STAGES + 1;
   localparam int CNT_W    = $clog2(ARM_LAST + 1);
   localparam logic [CNT_W-1:0] ARM_END = CNT_W'(ARM_LAST);

   logic [N_PINS-1:0] eff;
   logic [N_PINS-1:0] prev_q;
   logic [CNT_W-1:0]  arm_cnt_q;
   logic              armed_q;

   // Output pins read back their latch, input pins their pad.
   assign eff = (dir & out) | (~dir & pad_sync);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= '0;
         arm_cnt_q <= '0;
         armed_q   <= 1'b0;
      end else begin
         prev_q <= eff;
         if (!armed_q) begin
            arm_cnt_q <= arm_cnt_q + 1'b1;
            armed_q   <= (arm_cnt_q + 1'b1) == ARM_END;
         end
      end
   end

   assign armed = armed_q;

   generate
      for (genvar i = 0; i < N_PINS; i++) begin : g_pin
         sense_e mode;
         assign mode   = to_sense(sense_cfg[i*SENSE_W +: SENSE_W]);
         assign evt[i] = armed_q & sense_hit(mode, prev_q[i], eff[i]);
      end
   endgenerate

   // R12
   arm_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |=> armed_q);

endmodule

// File: rtl/gps_flags.sv
module gps_flags #(
   parameter int N_PINS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] evt,
   input  logic [N_PINS-1:0] clr_mask,
   output logic [N_PINS-1:0] flags,
   output logic              irq
);

   logic [N_PINS-1:0] flags_q;
   logic [N_PINS-1:0] flags_d;
   logic              irq_q;

   // New events win over a clear on the same bit.
   assign flags_d = (flags_q & ~clr_mask) | evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         flags_q <= flags_d;
         irq_q   <= |flags_d;
      end
   end

   assign flags = flags_q;
   assign irq   = irq_q;

   // R10
   irq_matches_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (flags_q != '0));

   generate
      for (genvar i = 0; i < N_PINS; i++) begin : g_chk
         // R8
         flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !clr_mask[i]) |=> flags_q[i]);
         // R9
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> flags_q[i]);
      end
   endgenerate

endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense
   import gps_pkg::*;
#(
   parameter int N_PINS      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_PINS-1:0]         dir,
   input  logic [N_PINS-1:0]         out,
   input  logic [N_PINS-1:0]         pad,
   input  logic [N_PINS*SENSE_W-1:0] sense_cfg,
   input  logic [N_PINS-1:0]         clr_mask,
   output logic [N_PINS-1:0]         flags,
   output logic                      irq
);

   initial begin
      assert (N_PINS >= 1 && N_PINS <= 64) else $error("gpio_pin_sense: N_PINS out of range");
   end

   logic [N_PINS-1:0] pad_sync;
   logic [N_PINS-1:0] evt;
   logic              armed;

   gps_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad),
      .q     (pad_sync)
   );

   gps_detect #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) i_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .dir       (dir),
      .out       (out),
      .pad_sync  (pad_sync),
      .sense_cfg (sense_cfg),
      .evt       (evt),
      .armed     (armed)
   );

   gps_flags #(.N_PINS(N_PINS)) i_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .clr_mask (clr_mask),
      .flags    (flags),
      .irq      (irq)
   );

   // R12
   no_flag_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (flags == '0));

   generate
      for (genvar i = 0; i < N_PINS; i++) begin : g_chk
         // R7
         off_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags[i] && to_sense(sense_cfg[i*SENSE_W +: SENSE_W]) == SENSE_OFF) |=> !flags[i]);
         // R8
         clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[i] && !evt[i]) |=> !flags[i]);
      end
   endgenerate

endmodule

// File: tb/test_gpio_pin_sense.sv
`timescale 1ns/1ps
module test_gpio_pin_sense;

   localparam int N  = 8;
   localparam int S  = 2;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  dir, out, pad, clr;
   logic [N*CW-1:0] cfg;
   logic [N-1:0]  flags;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   gpio_pin_sense #(.N_PINS(N), .SYNC_STAGES(S)) i_gpio_pin_sense (
      .clk(clk), .rst_n(rst_n), .dir(dir), .out(out), .pad(pad),
      .sense_cfg(cfg), .clr_mask(clr), .flags(flags), .irq(irq)
   );

   // Reference model built from the requirements.
   logic [S-1:0][N-1:0] m_sh;
   logic [N-1:0] m_prev, m_flags;
   logic         m_irq;
   int           m_cnt;

   function automatic logic m_hit(input logic [2:0] c, input logic p, input logic q);
      case (c)
         3'd1:    return p ^ q;
         3'd2:    return !p && q;
         3'd3:    return p && !q;
         3'd5:    return !q;
         default: return 1'b0;
      endcase
   endfunction

   always @(posedge clk) begin : mdl
      logic [N-1:0] eff, ev, nf;
      if (!rst_n) begin
         m_sh <= '0; m_prev <= '0; m_flags <= '0; m_irq <= 1'b0; m_cnt <= 0;
      end else begin
         eff = (dir & out) | (~dir & m_sh[S-1]);
         ev  = '0;
         if (m_cnt == S + 1)
            for (int i = 0; i < N; i++) ev[i] = m_hit(cfg[i*CW +: CW], m_prev[i], eff[i]);
         nf = (m_flags & ~clr) | ev;
         m_flags <= nf;
         m_irq   <= |nf;
         m_prev  <= eff;
         m_sh    <= {m_sh[S-2:0], pad};
         if (m_cnt < S + 1) m_cnt <= m_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      chk(flags === m_flags, "R8 flags vs model", flags, m_flags);
      chk(irq === m_irq, "R10 irq vs model", {7'd0, irq}, {7'd0, m_irq});
   endtask

   task automatic steps(input int n);
      for (int k = 0; k < n; k++) step();
   endtask

   task automatic setcfg(input int p, input logic [2:0] v);
      cfg[p*CW +: CW] = v;
   endtask

   task automatic clear_all();
      clr = '1; step(); clr = '0;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      dir = '0; out = '0; pad = '1; clr = '0; cfg = '0;
      setcfg(0, 3'd5);
      pad[0] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(flags == '0, "R12 reset flags", flags, '0);
      chk(irq == 1'b0, "R12 reset irq", {7'd0, irq}, '0);
      rst_n = 1'b1;

      // Arming window: low level held from reset, first flag after edge S+2.
      step(); chk(flags == '0, "R12 edge1", flags, '0);
      step(); chk(flags == '0, "R12 edge2", flags, '0);
      step(); chk(flags == '0, "R12 edge3", flags, '0);
      step(); chk(flags == 8'h01, "R6 low level sets", flags, 8'h01);
      chk(irq == 1'b1, "R10 irq raised", {7'd0, irq}, 8'h01);

      // Clear while still low is overridden.
      clr = 8'h01; step(); clr = '0;
      chk(flags == 8'h01, "R9 set beats clear", flags, 8'h01);
      chk(flags == 8'h01, "R6 re-set while low", flags, 8'h01);

      pad[0] = 1'b1; steps(3);
      clr = 8'h01; step(); clr = '0;
      chk(flags == '0, "R8 clear", flags, '0);
      chk(irq == 1'b0, "R10 irq dropped", {7'd0, irq}, '0);

      // Rising on pin 1.
      setcfg(1, 3'd2); pad[1] = 1'b0; steps(3);
      chk(flags == '0, "R4 fall ignored", flags, '0);
      pad[1] = 1'b1;
      step(); step();
      chk(flags[1] == 1'b0, "R11 pad not early", flags, '0);
      step();
      chk(flags == 8'h02, "R4 rise sets at S+1", flags, 8'h02);
      clr = 8'h02; step(); clr = 8'h00;
      chk(flags == '0, "R8 mask clears one bit", flags, '0);

      // Falling on pin 4.
      setcfg(4, 3'd3); pad[4] = 1'b0; steps(3);
      chk(flags == 8'h10, "R5 fall sets", flags, 8'h10);
      clr = 8'h10; step(); clr = '0;
      pad[4] = 1'b1; steps(3);
      chk(flags == '0, "R5 rise ignored", flags, '0);

      // Any change on pin 5.
      setcfg(5, 3'd1); pad[5] = 1'b0; steps(3);
      chk(flags == 8'h20, "R3 fall sets", flags, 8'h20);
      clr = 8'h20; step(); clr = '0;
      pad[5] = 1'b1; steps(3);
      chk(flags == 8'h20, "R3 rise sets", flags, 8'h20);
      clear_all();

      // Output pin 2: pad ignored, own latch triggers.
      setcfg(2, 3'd1); dir[2] = 1'b1; out[2] = 1'b1; steps(3);
      chk(flags == '0, "R1 no change on handover", flags, '0);
      pad[2] = 1'b0; steps(3);
      chk(flags == '0, "R1 pad ignored on output", flags, '0);
      out[2] = 1'b0; step();
      chk(flags == 8'h04, "R11 out change next edge", flags, 8'h04);
      chk(flags == 8'h04, "R1 output triggers", flags, 8'h04);
      clear_all();

      // Undefined code and off code on pin 3.
      setcfg(3, 3'd6); pad[3] = 1'b0; steps(3); pad[3] = 1'b1; steps(3);
      chk(flags == '0, "R2 code 6 inert", flags, '0);
      setcfg(3, 3'd0); pad[3] = 1'b0; steps(4);
      chk(flags == '0, "R7 off ignores low", flags, '0);

      // Random traffic against the model.
      for (int it = 0; it < 3000; it++) begin
         dir = N'($urandom);
         out = N'($urandom);
         pad = N'($urandom);
         clr = ($urandom % 4 == 0) ? N'($urandom) : '0;
         if ($urandom % 16 == 0) cfg = (N*CW)'($urandom);
         step();
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule